// File: doc/BRIEF.md
# SDRAM Precharge Timing Scheduler

This block tracks, for every bank of an SDRAM, the earliest cycle at which that bank may be closed after read and write column commands. The controller reports each column command it issues: the bank, read or write, the auto-precharge flag, CAS latency and burst length. From these the block keeps a per-bank countdown to the first legal precharge. The countdown is measured from the final data beat. For reads, the lead before the last beat depends on CAS latency. For writes, a write-recovery gap follows the last beat.

Explicit precharge requests are a single-cycle pulse. They carry no back-pressure and no data path. One cycle later the block answers each request with either an accept or a reject strobe. On an accept it drives the encoded precharge onto the command pins: row strobe low, column strobe high, write enable low, with bank-select and all-banks bits. A column command flagged for auto-precharge makes the bank close itself at its legal point. Explicit requests to that bank are refused until its precharge has completed. Per-bank idle flags show when each bank has finished precharging.

Top module: `sdram_pre_sched`

## Requirements
- R1: After reset every bank reads idle, every precharge-legal flag is 1, the command pins are at NOP (ras_n, cas_n, we_n all 1) and neither response strobe is set.
- R2: A read to a bank at cycle t with CAS latency CL (cmd_cas3=0 means 2, 1 means 3) and BL beats (cmd_burst code k gives 2^k beats) has its last data at t+CL+BL-1. A precharge to that bank becomes legal CL-1 cycles before that beat. pre_ok for the bank is 0 before that cycle and 1 from it, and an earlier request is rejected.
- R3: A write at cycle t with BL beats has its last data beat at t+BL-1. A precharge to that bank becomes legal T_WR cycles after that beat, and pre_ok and request acceptance follow that cycle.
- R4: A write with cmd_auto=1 starts an internal precharge in the cycle given by R3 (two clocks after the last beat with the default T_WR=2). The bank reads idle T_RP cycles after that start, and no command appears on the pins.
- R5: A read with cmd_auto=1 starts an internal precharge in the cycle given by R2. The bank reads idle T_RP cycles later.
- R6: An explicit precharge that targets a bank marked for auto-precharge, or a bank already precharging, is rejected.
- R7: A request in cycle k is answered in cycle k+1 by exactly one of pre_acc or pre_rej. On accept the pins carry ras_n=0, cas_n=1, we_n=0, sd_ba=pre_bank, sd_a10=pre_all. In every other cycle the pins are at NOP.
- R8: pre_all=1 targets every bank. It is accepted only when every bank is legal. After acceptance every open bank precharges. A rejected all-banks request leaves every bank unchanged.
- R9: pre_all=0 targets only the bank given by pre_bank. Other banks keep their state.
- R10: A column command to a bank that already has a pending wait never brings that bank's legal cycle earlier.
- R11: A precharge request in the same cycle as cmd_valid is rejected, because the command bus is taken.
- R12: A column command to a bank that is marked for auto-precharge or is precharging has no effect on that bank.
- R13: An explicit precharge accepted in cycle s makes the bank read idle from cycle s+T_RP. A precharge to a bank that is already idle is accepted and leaves it idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A column command is issued this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_auto | input | 1 | Auto-precharge flag (address bit 10 on the column command) |
| cmd_bank | input | BA_W | Bank of the column command |
| cmd_cas3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| cmd_burst | input | 2 | Burst length code, 2^code beats |
| pre_req | input | 1 | Explicit precharge request pulse |
| pre_all | input | 1 | 1 = all banks, 0 = single bank |
| pre_bank | input | BA_W | Bank for a single-bank precharge |
| pre_ok | output | NUM_BANKS | Per-bank flag: a precharge to this bank is legal now |
| bank_idle | output | NUM_BANKS | Per-bank flag: bank is closed and precharged |
| pre_acc | output | 1 | Request from the previous cycle accepted |
| pre_rej | output | 1 | Request from the previous cycle rejected |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select of the issued precharge |
| sd_a10 | output | 1 | All-banks bit of the issued precharge |

## Verification
Reads are applied at both CAS latencies with different burst lengths. This shows whether the legal point is counted back from the last data beat, rather than from the command or with a fixed lead. Writes of several lengths separate the write-recovery offset from the read rule. Auto-precharge reads and writes are combined with refused explicit requests and ignored column commands, which exposes a bank that leaves its reserved state too early. All-banks, single-bank, idle-bank and bus-collision requests, plus a short command that follows a long one on the same bank, check the bank selection and confirm that a pending wait is never shortened.

// File: rtl/psch_pkg.sv
`timescale 1ns/1ps
package psch_pkg;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_AUTO  = 2'd2,
    BK_PRECH = 2'd3
  } bank_st_e;

  function automatic int unsigned burst_beats(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Counter load for a column command: the legal precharge cycle is
  // (load + 1) cycles after the command, since counting starts next cycle.
  function automatic int unsigned col_wait(input logic is_wr, input logic cas3,
                                           input logic [1:0] bl_code,
                                           input int unsigned t_wr);
    int unsigned cl;
    int unsigned beats;
    int unsigned last_beat;
    int unsigned legal;
    cl    = cas3 ? 32'd3 : 32'd2;
    beats = burst_beats(bl_code);
    if (is_wr) begin
      last_beat = beats - 1;
      legal     = last_beat + t_wr;
    end else begin
      last_beat = cl + beats - 1;
      legal     = last_beat - (cl - 1);
    end
    return legal - 1;
  endfunction

endpackage

// File: rtl/psch_bank.sv
`timescale 1ns/1ps
module psch_bank
  import psch_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             col_hit,
  input  logic             col_auto,
  input  logic [CNT_W-1:0] col_wait,
  input  logic             pre_take,
  output logic             pre_ok,
  output logic             idle
);

  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(T_RP - 2);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;

  assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_dec;
    unique case (st_q)
      BK_IDLE: begin
        if (col_hit) begin
          st_d  = col_auto ? BK_AUTO : BK_OPEN;
          cnt_d = col_wait;
        end
      end
      BK_OPEN: begin
        if (pre_take) begin
          st_d  = BK_PRECH;
          cnt_d = RP_LOAD;
        end else if (col_hit) begin
          st_d  = col_auto ? BK_AUTO : BK_OPEN;
          cnt_d = (col_wait > cnt_dec) ? col_wait : cnt_dec;
        end
      end
      BK_AUTO: begin
        if (cnt_q == '0) begin
          st_d  = BK_PRECH;
          cnt_d = RP_LOAD;
        end
      end
      BK_PRECH: begin
        if (cnt_q == '0) st_d = BK_IDLE;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pre_ok = (st_q == BK_IDLE) || ((st_q == BK_OPEN) && (cnt_q == '0));
  assign idle   = (st_q == BK_IDLE);

  // R12: a bank reserved for auto-precharge stays reserved until its start
  p_auto_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_AUTO && cnt_q != '0) |=> (st_q == BK_AUTO));

  // R13: the precharge window ends in idle
  p_prech_ends_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_PRECH && cnt_q == '0) |=> idle);

  // R10: a later column command never shortens the pending wait
  p_wait_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_OPEN && col_hit && !pre_take && cnt_q != '0)
      |=> (cnt_q >= $past(cnt_q) - 1'b1));

endmodule

// File: rtl/psch_pre_gate.sv
`timescale 1ns/1ps
module psch_pre_gate #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 pre_req,
  input  logic                 pre_all,
  input  logic [BA_W-1:0]      pre_bank,
  input  logic                 bus_busy,
  input  logic [NUM_BANKS-1:0] bank_ok,
  output logic                 grant,
  output logic                 deny,
  output logic [NUM_BANKS-1:0] take
);

  logic [NUM_BANKS-1:0] target;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_tgt
    assign target[i] = pre_all || (pre_bank == BA_W'(i));
  end

  assign grant = pre_req && !bus_busy && (&(bank_ok | ~target));
  assign deny  = pre_req && !grant;
  assign take  = target & {NUM_BANKS{grant}};

endmodule

// File: rtl/psch_cmd_reg.sv
`timescale 1ns/1ps
module psch_cmd_reg #(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  input  logic            deny,
  input  logic [BA_W-1:0] bank,
  input  logic            all,
  output logic            acc,
  output logic            rej,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [BA_W-1:0] ba,
  output logic            a10
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= 1'b0;
      rej   <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      a10   <= 1'b0;
    end else begin
      acc   <= grant;
      rej   <= deny;
      ras_n <= !grant;
      cas_n <= 1'b1;
      we_n  <= !grant;
      ba    <= grant ? bank : '0;
      a10   <= grant && all;
    end
  end

  // R7: at most one answer per request
  p_one_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && rej));

endmodule

// File: rtl/sdram_pre_sched.sv
`timescale 1ns/1ps
module sdram_pre_sched
  import psch_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int T_RP      = 3,
  parameter  int T_WR      = 2,
  localparam int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic                 cmd_auto,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic                 cmd_cas3,
  input  logic [1:0]           cmd_burst,
  input  logic                 pre_req,
  input  logic                 pre_all,
  input  logic [BA_W-1:0]      pre_bank,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] bank_idle,
  output logic                 pre_acc,
  output logic                 pre_rej,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [BA_W-1:0]      sd_ba,
  output logic                 sd_a10
);

  localparam int CNT_W = $clog2(8 + T_WR + T_RP + 1);

  logic [CNT_W-1:0]     wait_val;
  logic [NUM_BANKS-1:0] take;
  logic                 grant, deny;

  assign wait_val = CNT_W'(col_wait(cmd_write, cmd_cas3, cmd_burst, T_WR));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    psch_bank #(.CNT_W(CNT_W), .T_RP(T_RP)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .col_hit  (cmd_valid && (cmd_bank == BA_W'(i))),
      .col_auto (cmd_auto),
      .col_wait (wait_val),
      .pre_take (take[i]),
      .pre_ok   (pre_ok[i]),
      .idle     (bank_idle[i])
    );
  end

  psch_pre_gate #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_gate (
    .pre_req  (pre_req),
    .pre_all  (pre_all),
    .pre_bank (pre_bank),
    .bus_busy (cmd_valid),
    .bank_ok  (pre_ok),
    .grant    (grant),
    .deny     (deny),
    .take     (take)
  );

  psch_cmd_reg #(.BA_W(BA_W)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .grant (grant),
    .deny  (deny),
    .bank  (pre_bank),
    .all   (pre_all),
    .acc   (pre_acc),
    .rej   (pre_rej),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ba    (sd_ba),
    .a10   (sd_a10)
  );

  // R11: an accepted precharge never shared its cycle with a column command
  p_bus_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pre_acc |-> $past(!cmd_valid));

  // R7: every answer follows a request one cycle earlier
  p_answer_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_acc || pre_rej) |-> $past(pre_req));

  // R6: a bank that was not legal does not go idle through an explicit grant
  p_no_early_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_req && !pre_all && !pre_ok[pre_bank]) |=> pre_rej);

endmodule

// File: tb/sim_sdram_pre_sched.sv
`timescale 1ns/1ps
module sim_sdram_pre_sched;
  localparam int NB = 4, T_RP = 3, T_WR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 0, cmd_write = 0, cmd_auto = 0, cmd_cas3 = 0;
  logic [1:0] cmd_bank = 0, cmd_burst = 0, pre_bank = 0, sd_ba;
  logic pre_req = 0, pre_all = 0;
  logic [NB-1:0] pre_ok, bank_idle;
  logic pre_acc, pre_rej, sd_ras_n, sd_cas_n, sd_we_n, sd_a10;

  sdram_pre_sched #(.NUM_BANKS(NB), .T_RP(T_RP), .T_WR(T_WR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_auto(cmd_auto), .cmd_bank(cmd_bank), .cmd_cas3(cmd_cas3),
    .cmd_burst(cmd_burst), .pre_req(pre_req), .pre_all(pre_all),
    .pre_bank(pre_bank), .pre_ok(pre_ok), .bank_idle(bank_idle),
    .pre_acc(pre_acc), .pre_rej(pre_rej), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a10(sd_a10));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {bit acc; bit all; int bank; int due; string req;} exp_t;
  exp_t sbq[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected answers and compares the pins
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && !done) begin
      if (pre_acc || pre_rej) begin
        if (sbq.size() == 0) chk(0, "R7", "unexpected answer", 1, 0);
        else begin
          e = sbq.pop_front();
          chk(e.due == cyc, e.req, "answer cycle", cyc, e.due);
          chk(pre_acc == e.acc, e.req, "accept", pre_acc, e.acc);
          chk(pre_rej == !e.acc, e.req, "reject", pre_rej, !e.acc);
          if (e.acc) begin
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b010, "R7", "pins",
                {sd_ras_n, sd_cas_n, sd_we_n}, 3'b010);
            chk(sd_a10 == e.all, "R7", "a10", sd_a10, e.all);
            if (!e.all) chk(sd_ba == 2'(e.bank), "R7", "ba", sd_ba, e.bank);
          end else
            chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R7", "nop on reject",
                {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
        end
      end else begin
        if (sbq.size() != 0 && sbq[0].due <= cyc) begin
          chk(0, sbq[0].req, "missing answer", 0, 1);
          void'(sbq.pop_front());
        end
        if ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111)
          chk(0, "R7", "pins not NOP", {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic col(int bank, bit wr, bit ap, bit c3, int code);
    cmd_valid = 1; cmd_bank = 2'(bank); cmd_write = wr; cmd_auto = ap;
    cmd_cas3 = c3; cmd_burst = 2'(code);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pre(bit all, int bank, bit exp_acc, string req);
    pre_req = 1; pre_all = all; pre_bank = 2'(bank);
    sbq.push_back('{acc: exp_acc, all: all, bank: bank, due: cyc + 1, req: req});
    @(negedge clk);
    pre_req = 0;
  endtask

  task automatic close(int bank);
    while (!pre_ok[bank]) tick();
    pre(0, bank, 1, "R13");
    tick(T_RP);
  endtask

  function automatic int rd_legal(int cl, int beats);
    return (cl + beats - 1) - (cl - 1);
  endfunction
  function automatic int wr_legal(int beats);
    return (beats - 1) + T_WR;
  endfunction

  initial begin : drv
    int t0, t1, s, l;
    tick(3);
    rst_n = 1;
    tick();
    // R1
    chk(bank_idle == 4'hF, "R1", "idle", bank_idle, 15);
    chk(pre_ok == 4'hF, "R1", "pre_ok", pre_ok, 15);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "pins", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(!pre_acc && !pre_rej, "R1", "strobes", {pre_acc, pre_rej}, 0);

    // R2 CL2, 4 beats, bank 0
    t0 = cyc; l = rd_legal(2, 4);
    col(0, 0, 0, 0, 2);
    chk(bank_idle[0] == 0, "R2", "bank opened", bank_idle[0], 0);
    wait_to(t0 + 2); pre(0, 0, 0, "R2");
    wait_to(t0 + l - 1); chk(pre_ok[0] == 0, "R2", "ok early", pre_ok[0], 0);
    wait_to(t0 + l);     chk(pre_ok[0] == 1, "R2", "ok at legal", pre_ok[0], 1);
    s = cyc; pre(0, 0, 1, "R2");
    wait_to(s + T_RP - 1); chk(bank_idle[0] == 0, "R13", "idle early", bank_idle[0], 0);
    wait_to(s + T_RP);     chk(bank_idle[0] == 1, "R13", "idle after tRP", bank_idle[0], 1);

    // R2 CL3, 2 beats, bank 1
    t0 = cyc; l = rd_legal(3, 2);
    col(1, 0, 0, 1, 1);
    wait_to(t0 + l - 1); chk(pre_ok[1] == 0, "R2", "cl3 ok early", pre_ok[1], 0);
    wait_to(t0 + l);     chk(pre_ok[1] == 1, "R2", "cl3 ok at legal", pre_ok[1], 1);
    close(1);

    // R3 write, 4 beats, bank 2
    t0 = cyc; l = wr_legal(4);
    col(2, 1, 0, 0, 2);
    wait_to(t0 + l - 1); chk(pre_ok[2] == 0, "R3", "ok early", pre_ok[2], 0);
    pre(0, 2, 0, "R3");
    chk(pre_ok[2] == 1, "R3", "ok at legal", pre_ok[2], 1);
    pre(0, 2, 1, "R3");
    tick(T_RP);

    // R4 auto write, 2 beats, bank 3
    t0 = cyc; s = t0 + wr_legal(2);
    col(3, 1, 1, 0, 1);
    pre(0, 3, 0, "R6");
    wait_to(s + 1); chk(pre_ok[3] == 0, "R4", "ok while precharging", pre_ok[3], 0);
    wait_to(s + T_RP - 1); chk(bank_idle[3] == 0, "R4", "idle early", bank_idle[3], 0);
    wait_to(s + T_RP);     chk(bank_idle[3] == 1, "R4", "idle", bank_idle[3], 1);

    // R5 auto read CL3, 8 beats, bank 0
    t0 = cyc; s = t0 + rd_legal(3, 8);
    col(0, 0, 1, 1, 3);
    wait_to(s + 1); pre(0, 0, 0, "R6");
    wait_to(s + T_RP - 1); chk(bank_idle[0] == 0, "R5", "idle early", bank_idle[0], 0);
    wait_to(s + T_RP);     chk(bank_idle[0] == 1, "R5", "idle", bank_idle[0], 1);

    // R8 all banks
    t0 = cyc;
    col(1, 0, 0, 0, 0);
    t1 = cyc;
    col(2, 1, 0, 0, 3);
    pre(1, 0, 0, "R8");
    chk(pre_ok[1] == 1 && bank_idle[1] == 0, "R8", "bank1 untouched", {pre_ok[1], bank_idle[1]}, 2);
    wait_to(t1 + wr_legal(8)); chk(pre_ok == 4'hF, "R8", "all legal", pre_ok, 15);
    s = cyc; pre(1, 0, 1, "R8");
    wait_to(s + T_RP); chk(bank_idle == 4'hF, "R8", "all idle", bank_idle, 15);

    // R9 single bank
    t0 = cyc;
    col(0, 0, 0, 0, 0);
    col(1, 0, 0, 0, 0);
    s = cyc; pre(0, 1, 1, "R9");
    wait_to(s + T_RP);
    chk(bank_idle[1] == 1 && bank_idle[0] == 0, "R9", "only bank1 closed", bank_idle, 2'b10);
    close(0);

    // R10 wait never shortened
    t0 = cyc; l = wr_legal(8);
    col(2, 1, 0, 0, 3);
    col(2, 0, 0, 0, 0);
    wait_to(t0 + 3);     chk(pre_ok[2] == 0, "R10", "ok after short read", pre_ok[2], 0);
    wait_to(t0 + l - 1); chk(pre_ok[2] == 0, "R10", "ok before write legal", pre_ok[2], 0);
    wait_to(t0 + l);     chk(pre_ok[2] == 1, "R10", "ok at write legal", pre_ok[2], 1);
    close(2);

    // R11 bus collision
    cmd_valid = 1; cmd_bank = 2'd1; cmd_write = 0; cmd_auto = 0; cmd_burst = 0;
    pre(0, 0, 0, "R11");
    cmd_valid = 0;
    chk(bank_idle[0] == 1, "R11", "bank0 still idle", bank_idle[0], 1);
    close(1);

    // R12 column command to auto bank ignored
    t0 = cyc; s = t0 + rd_legal(2, 4);
    col(3, 0, 1, 0, 2);
    wait_to(t0 + 2); col(3, 1, 0, 0, 3);
    wait_to(s + T_RP - 1); chk(bank_idle[3] == 0, "R12", "idle early", bank_idle[3], 0);
    wait_to(s + T_RP);     chk(bank_idle[3] == 1, "R12", "idle on time", bank_idle[3], 1);
    chk(pre_ok[3] == 1, "R12", "ok after close", pre_ok[3], 1);

    // R13 precharge to an idle bank
    s = cyc; pre(0, 2, 1, "R13");
    chk(bank_idle[2] == 1, "R13", "idle bank stays idle", bank_idle[2], 1);
    tick(2);
    chk(bank_idle == 4'hF, "R13", "all idle", bank_idle, 15);

    tick(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule